// File: doc/BRIEF.md
# Two-Wire Serial Memory Write Slave

This block is the target side of a two-wire serial memory with 128 bytes of storage and no separate device-select byte. It synchronises the clock and data lines to the system clock and finds start and stop conditions on them. The first byte of each transfer holds the 7-bit memory word address followed by a direction bit. Data bytes that follow are acknowledged and collected in a four-entry page buffer.

A stop condition that follows at least one complete data byte starts a timed internal write cycle. During that cycle the buffered bytes are copied into the storage array, and the block ignores the bus until the cycle ends. A synchronous read port gives the surrounding logic access to the array contents.

The data line is open-drain. The block only ever pulls it low, through `sda_oe`.

Top module: `twi_pagewr_slave`

## Requirements
- R1: A start is a falling SDA while SCL is high, and a stop is a rising SDA while SCL is high, both seen after synchronisation. Bits clocked before any start are ignored and get no acknowledge.
- R2: After a start, the first byte is taken MSB first as a 7-bit word address followed by a direction bit in the LSB, where 0 means write. For a write, `sda_oe` is asserted from the SCL fall after the eighth bit until the SCL fall that ends the ninth clock.
- R3: A direction bit of 1 gets no acknowledge. Every following byte up to the next start or stop gets no acknowledge, and nothing is written to the array.
- R4: In a write transfer, every complete 8-bit data byte is acknowledged on the ninth clock.
- R5: Each data byte is placed at the current word address. After each byte only the two low address bits increment, wrapping from 3 to 0. The upper five bits, which select the page, never change.
- R6: When more than four data bytes arrive before stop, later bytes overwrite earlier ones in the same page slot. A fifth byte lands where the first one went.
- R7: A stop after at least one acknowledged data byte raises `busy` for exactly WR_CYCLES clocks. During that time only the page locations written in the transfer are updated, and the rest of the array is left unchanged.
- R8: A stop with no acknowledged data byte starts no write cycle and changes nothing. A trailing partial byte (stop before its eighth bit) is discarded, while the complete bytes before it are still committed.
- R9: While `busy` is high, start, stop and data on the bus are ignored and no acknowledge is given. When `busy` falls, the block waits idle for a new start.
- R10: A start in the middle of a transfer restarts address reception and discards any data bytes not yet committed.
- R11: After reset, `sda_oe` and `busy` are 0 and the block waits idle for a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | Pull the data line low when 1 (acknowledge) |
| busy | output | 1 | Internal write cycle in progress |
| rd_addr | input | 7 | Array read address |
| rd_data | output | 8 | Array read data, one clock after `rd_addr` |

## Verification
The page write is driven with transfers of one, three, four, two and six data bytes, starting at different page offsets. These patterns separate a plain store from low-bit address increment, from wrap at the top of the page, and from slot overwrite on a sixth byte. Directed transfers then send:
- a read-direction byte;
- an address with no data;
- a trailing partial byte;
- a full transfer during the write cycle;
- a restart in the middle of a page.

Each of these is told apart by reading back locations whose values are already known and must not move. The write-cycle length is measured on `busy` in every committed case.

// File: rtl/twi_pw_pkg.sv
package twi_pw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RX   = 3'd1,
    ST_ACK  = 3'd2,
    ST_SKIP = 3'd3,
    ST_BUSY = 3'd4
  } pw_state_t;

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic start_p,
  output logic stop_p,
  output logic rise_p,
  output logic fall_p
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_q;
  logic              sda_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_pipe[g] <= 1'b1;
          sda_pipe[g] <= 1'b1;
        end else begin
          scl_pipe[g] <= scl_i;
          sda_pipe[g] <= sda_i;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_pipe[g] <= 1'b1;
          sda_pipe[g] <= 1'b1;
        end else begin
          scl_pipe[g] <= scl_pipe[g-1];
          sda_pipe[g] <= sda_pipe[g-1];
        end
      end
    end
  end

  assign scl_s = scl_pipe[STAGES-1];
  assign sda_s = sda_pipe[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign start_p = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_p  = scl_s & scl_q & ~sda_q & sda_s;
  assign rise_p  = scl_s & ~scl_q;
  assign fall_p  = ~scl_s & scl_q;

endmodule

// File: rtl/twi_page_buf.sv
module twi_page_buf #(
  parameter int PAGE_W = 2,
  parameter int DATA_W = 8,
  localparam int SLOTS = 1 << PAGE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PAGE_W-1:0] rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [SLOTS-1:0]  valid
);

  logic [DATA_W-1:0] slot_q [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        valid[g] <= 1'b0;
      end else if (wr_en && wr_idx == PAGE_W'(g)) begin
        valid[g] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_en && wr_idx == PAGE_W'(g)) begin
        slot_q[g] <= wr_data;
      end
    end
  end

  assign rd_data = slot_q[rd_idx];

endmodule

// File: rtl/twi_mem_array.sv
module twi_mem_array #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      cells[waddr] <= wdata;
    end
    rdata <= cells[raddr];
  end

endmodule

// File: rtl/twi_pagewr_slave.sv
module twi_pagewr_slave
  import twi_pw_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int PAGE_W      = 2,
  parameter int WR_CYCLES   = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic              busy,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int SLOTS  = 1 << PAGE_W;
  localparam int CNT_W  = $clog2(WR_CYCLES + 1);
  localparam int BIT_W  = $clog2(DATA_W);
  localparam int PAGE_HI = ADDR_W - PAGE_W;

  // line conditioning
  logic scl_s, sda_s, start_p, stop_p, rise_p, fall_p;

  twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .scl_i   (scl_i),
    .sda_i   (sda_i),
    .scl_s   (scl_s),
    .sda_s   (sda_s),
    .start_p (start_p),
    .stop_p  (stop_p),
    .rise_p  (rise_p),
    .fall_p  (fall_p)
  );

  // control state
  pw_state_t          state;
  logic [BIT_W-1:0]   bitcnt;
  logic               got;
  logic               first_byte;
  logic [DATA_W-1:0]  shreg;
  logic [ADDR_W-1:0]  addr;
  logic [CNT_W-1:0]   wcnt;
  logic [PAGE_HI-1:0] page;

  // page buffer
  logic               buf_we, buf_clr;
  logic [DATA_W-1:0]  buf_rdata;
  logic [SLOTS-1:0]   buf_valid;

  // array write port
  logic               mem_we;
  logic [ADDR_W-1:0]  mem_waddr;

  logic byte_fin;

  assign page     = addr[ADDR_W-1:PAGE_W];
  assign byte_fin = (state == ST_RX) && fall_p && got && !start_p && !stop_p;
  assign buf_we   = byte_fin && !first_byte;
  assign buf_clr  = start_p && (state != ST_BUSY);

  twi_page_buf #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_buf (
    .clk     (clk),
    .rst     (rst),
    .clr     (buf_clr),
    .wr_en   (buf_we),
    .wr_idx  (addr[PAGE_W-1:0]),
    .wr_data (shreg),
    .rd_idx  (wcnt[PAGE_W-1:0]),
    .rd_data (buf_rdata),
    .valid   (buf_valid)
  );

  assign mem_we    = (state == ST_BUSY) && (wcnt < CNT_W'(SLOTS))
                     && buf_valid[wcnt[PAGE_W-1:0]];
  assign mem_waddr = {page, wcnt[PAGE_W-1:0]};

  twi_mem_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (buf_rdata),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      sda_oe     <= 1'b0;
      busy       <= 1'b0;
      bitcnt     <= '0;
      got        <= 1'b0;
      first_byte <= 1'b0;
      shreg      <= '0;
      addr       <= '0;
      wcnt       <= '0;
    end else if (state == ST_BUSY) begin
      // bus is not looked at while the array is being written
      if (wcnt == CNT_W'(WR_CYCLES - 1)) begin
        state <= ST_IDLE;
        busy  <= 1'b0;
        wcnt  <= '0;
      end else begin
        wcnt <= wcnt + 1'b1;
      end
    end else if (start_p) begin
      state      <= ST_RX;
      sda_oe     <= 1'b0;
      bitcnt     <= '0;
      got        <= 1'b0;
      first_byte <= 1'b1;
    end else if (stop_p) begin
      sda_oe <= 1'b0;
      if (state != ST_IDLE && |buf_valid) begin
        state <= ST_BUSY;
        busy  <= 1'b1;
        wcnt  <= '0;
      end else begin
        state <= ST_IDLE;
      end
    end else begin
      unique case (state)
        ST_RX: begin
          if (rise_p && !got) begin
            shreg <= {shreg[DATA_W-2:0], sda_s};
            if (bitcnt == BIT_W'(DATA_W - 1)) begin
              got <= 1'b1;
            end else begin
              bitcnt <= bitcnt + 1'b1;
            end
          end
          if (byte_fin) begin
            if (first_byte) begin
              addr <= shreg[ADDR_W:1];
              if (!shreg[0]) begin
                state  <= ST_ACK;
                sda_oe <= 1'b1;
              end else begin
                state <= ST_SKIP;
              end
            end else begin
              addr[PAGE_W-1:0] <= addr[PAGE_W-1:0] + PAGE_W'(1);
              state  <= ST_ACK;
              sda_oe <= 1'b1;
            end
          end
        end
        ST_ACK: begin
          if (fall_p) begin
            sda_oe     <= 1'b0;
            state      <= ST_RX;
            first_byte <= 1'b0;
            got        <= 1'b0;
            bitcnt     <= '0;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/twi_pagewr_chk.sv
module twi_pagewr_chk #(
  parameter int WR_CYCLES = 1000,
  parameter int PG_W      = 5
) (
  input logic            clk,
  input logic            rst,
  input logic            sda_oe,
  input logic            busy,
  input logic            scl_s,
  input logic            stop_p,
  input logic            mem_we,
  input logic [PG_W-1:0] page
);

  int unsigned busy_run;

  always_ff @(posedge clk) begin
    if (rst || !busy) busy_run <= 0;
    else              busy_run <= busy_run + 1;
  end

  // R9: no acknowledge while the write cycle runs
  a_r9_quiet_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> !sda_oe);

  // R2: acknowledge is raised only while the clock line is low
  a_r2_ack_scl_low: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_s);

  // R7: a write cycle opens only on a stop condition
  a_r7_busy_after_stop: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(stop_p));

  // R7: the array is written only inside the write cycle
  a_r7_write_in_busy: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);

  // R7: the write cycle lasts exactly WR_CYCLES clocks
  a_r7_busy_len: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($past(busy_run) == WR_CYCLES - 1));

  // R5: page bits held for the whole commit
  a_r5_page_fixed: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(page));

endmodule

bind twi_pagewr_slave twi_pagewr_chk #(
  .WR_CYCLES (WR_CYCLES),
  .PG_W      (ADDR_W - PAGE_W)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .sda_oe (sda_oe),
  .busy   (busy),
  .scl_s  (scl_s),
  .stop_p (stop_p),
  .mem_we (mem_we),
  .page   (page)
);

// File: tb/twi_pagewr_slave_tb_top.sv
module twi_pagewr_slave_tb_top;

  localparam int WRC = 600;
  localparam int H   = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_bus;
  logic       sda_oe;
  logic       busy;
  logic [6:0] rd_addr = '0;
  logic [7:0] rd_data;

  int n_chk  = 0;
  int n_fail = 0;

  logic [7:0] mdl   [128];
  bit         known [128];

  int busy_run  = 0;
  int last_len  = 0;

  always #4 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;

  twi_pagewr_slave #(.WR_CYCLES(WRC)) dut_i (
    .clk     (clk),
    .rst     (rst),
    .scl_i   (scl),
    .sda_i   (sda_bus),
    .sda_oe  (sda_oe),
    .busy    (busy),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  always @(negedge clk) begin
    if (busy) busy_run <= busy_run + 1;
    else begin
      if (busy_run != 0) last_len <= busy_run;
      busy_run <= 0;
    end
  end

  // addr[6:0], byte count[2:0], first data byte[7:0]
  localparam logic [17:0] VEC [5] = '{
    {7'h00, 3'd1, 8'hA5},
    {7'h11, 3'd3, 8'h3C},
    {7'h2A, 3'd4, 8'h10},
    {7'h45, 3'd6, 8'h70},
    {7'h7F, 3'd2, 8'hE1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic hw(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hw(H);
    scl   = 1'b1; hw(H);
    sda_m = 1'b0; hw(H);
    scl   = 1'b0; hw(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hw(H);
    scl   = 1'b1; hw(H);
    sda_m = 1'b1;
  endtask

  task automatic send_bit(input logic b);
    sda_m = b;    hw(H);
    scl   = 1'b1; hw(H);
    scl   = 1'b0; hw(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; hw(H);
    scl   = 1'b1; hw(H / 2);
    @(negedge clk);
    ack = !sda_bus;
    hw(H / 2);
    scl = 1'b0; hw(H);
  endtask

  task automatic read_mem(input logic [6:0] a, output logic [7:0] d);
    rd_addr = a;
    hw(3);
    @(negedge clk);
    d = rd_data;
  endtask

  // waits for a write cycle; seen=0 if busy never rises
  task automatic commit_wait(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (busy) seen = 1'b1;
    end
    if (seen) begin
      while (busy) @(negedge clk);
      @(negedge clk);
    end
  endtask

  task automatic check_cell(input logic [6:0] a, input string req);
    logic [7:0] d;
    if (known[a]) begin
      read_mem(a, d);
      chk(d == mdl[a], req, d, mdl[a]);
    end
  endtask

  task automatic check_page(input logic [6:0] a, input string req);
    for (int s = 0; s < 4; s++) check_cell({a[6:2], 2'(s)}, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R7 watchdog expired act=0 exp=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit ack, seen;
    logic [7:0] d;
    for (int i = 0; i < 128; i++) known[i] = 1'b0;

    hw(5);
    rst = 1'b0;
    hw(2);
    @(negedge clk);
    // R11: idle outputs after reset
    chk(sda_oe == 1'b0, "R11 sda_oe after reset", sda_oe, 0);
    chk(busy == 1'b0, "R11 busy after reset", busy, 0);

    // R1: a byte with no start is not acknowledged
    send_byte(8'h20, ack);
    chk(!ack, "R1 no start no ack", ack, 0);
    bus_stop();
    commit_wait(seen);
    chk(!seen, "R1 stray stop no write", seen, 0);

    // vector table: page writes, R2 R4 R5 R6 R7
    foreach (VEC[v]) begin
      logic [6:0] a;
      int         n;
      logic [7:0] base;
      a    = VEC[v][17:11];
      n    = int'(VEC[v][10:8]);
      base = VEC[v][7:0];
      bus_start();
      send_byte({a, 1'b0}, ack);
      chk(ack, "R2 address ack", ack, 1);
      for (int k = 0; k < n; k++) begin
        logic [7:0] dk;
        logic [6:0] ak;
        dk = base + 8'(k * 29);
        send_byte(dk, ack);
        chk(ack, "R4 data ack", ack, 1);
        ak = {a[6:2], 2'(a[1:0] + 2'(k))};
        mdl[ak]   = dk;
        known[ak] = 1'b1;
      end
      bus_stop();
      commit_wait(seen);
      chk(seen, "R7 write cycle starts", seen, 1);
      chk(last_len == WRC, "R7 write cycle length", last_len, WRC);
      check_page(a, n > 4 ? "R6 page overwrite" : "R5 page contents");
    end

    // R3: read direction is not acknowledged and writes nothing
    bus_start();
    send_byte({7'h11, 1'b1}, ack);
    chk(!ack, "R3 read dir no ack", ack, 0);
    send_byte(8'h55, ack);
    chk(!ack, "R3 following byte no ack", ack, 0);
    bus_stop();
    commit_wait(seen);
    chk(!seen, "R3 no write cycle", seen, 0);
    check_page(7'h11, "R3 array unchanged");

    // R8: address only, then stop
    bus_start();
    send_byte({7'h12, 1'b0}, ack);
    chk(ack, "R8 address ack", ack, 1);
    bus_stop();
    commit_wait(seen);
    chk(!seen, "R8 no data no write", seen, 0);

    // R8: full byte then partial byte
    bus_start();
    send_byte({7'h12, 1'b0}, ack);
    send_byte(8'h9A, ack);
    chk(ack, "R8 full byte ack", ack, 1);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_stop();
    commit_wait(seen);
    chk(seen, "R8 full byte committed", seen, 1);
    mdl[7'h12] = 8'h9A;
    check_page(7'h12, "R8 partial byte discarded");

    // R9: traffic during the write cycle is ignored
    bus_start();
    send_byte({7'h20, 1'b0}, ack);
    send_byte(8'h01, ack);
    bus_stop();
    mdl[7'h20] = 8'h01; known[7'h20] = 1'b1;
    hw(4);
    bus_start();
    send_byte({7'h2A, 1'b0}, ack);
    chk(!ack, "R9 no ack while busy", ack, 0);
    send_byte(8'hEE, ack);
    chk(!ack, "R9 no data ack while busy", ack, 0);
    bus_stop();
    @(negedge clk);
    chk(busy, "R9 still busy", busy, 1);
    commit_wait(seen);
    chk(last_len == WRC, "R9 cycle length unaffected", last_len, WRC);
    check_page(7'h20, "R9 first commit");
    check_page(7'h2A, "R9 ignored write");

    // R10: restart discards buffered bytes
    bus_start();
    send_byte({7'h2B, 1'b0}, ack);
    send_byte(8'h77, ack);
    chk(ack, "R9 idle after cycle ack", ack, 1);
    bus_start();
    send_byte({7'h29, 1'b0}, ack);
    chk(ack, "R10 restart address ack", ack, 1);
    send_byte(8'h66, ack);
    bus_stop();
    commit_wait(seen);
    mdl[7'h29] = 8'h66;
    check_page(7'h29, "R10 restart page");

    read_mem(7'h7C, d);
    chk(d == mdl[7'h7C], "R5 top page wrap", d, mdl[7'h7C]);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule